// File: doc/BRIEF.md
# UART Auxiliary Register Bank

This block holds the side registers that go with a 16550-compatible serial core: two mode registers, a supplementary control byte, an early-break byte, a wakeup-enable mask, a clock prescale byte, a one-bit clock selector and a system configuration byte. It also answers three read-only identification and status locations with fixed values. A host reaches the registers through a plain register bus: an address, a write strobe with data, and a read strobe. Read data comes back one cycle later.

Only the low eight bits of the address are decoded, so the bank repeats every 256 bytes. Any access to a location outside the decoded set produces a one-cycle error pulse. A write to one of the constant locations produces a separate one-cycle pulse. Writing the configuration byte with its reset bit set returns the clocking and wakeup registers to their defaults, and leaves the mode and control registers as they are.

Top module: `uxb_ext_regs`

## Requirements
- R1: Only address bits 7:0 are decoded. Two addresses that differ only above bit 7 reach the same register.
- R2: Offset 0x20 (mode A) stores write bits 6:0 and reads bit 7 as 0. Offset 0x24 (mode B) stores all 8 bits.
- R3: Offset 0x40 (supplementary control) and offset 0x48 (early break) each store all 8 written bits.
- R4: Offsets 0x44, 0x50 and 0x58 always read 0x00, 0x30 and 0x01. A write to any of them changes no register and raises `ro_err` for the one cycle after the write.
- R5: Offset 0x4C (clock select) stores only write bit 0. Bits 7:1 read as 0.
- R6: Offset 0x54 (system configuration) stores the written value ANDed with 0x1D. A write with bit 1 set performs a soft reset instead, and the register then reads 0x00.
- R7: A soft reset sets early break to 0x00, system configuration to 0x00, wakeup enable to 0x3F, prescale to 0x69 and clock select to 0. Mode A, mode B and supplementary control keep their values.
- R8: Offset 0x5C (wakeup enable) stores write bits 6:0. Offset 0x60 (prescale) stores all 8 bits.
- R9: While `rst` is high at a clock edge, mode A, mode B, supplementary control, early break and system configuration become 0x00, wakeup enable becomes 0x3F, prescale becomes 0x69, clock select becomes 0, and `rd_data`, `err` and `ro_err` become 0.
- R10: An offset other than the eleven listed is undecoded. This includes unaligned offsets, the gap 0x28–0x3C, offsets below 0x20 and offsets above 0x60. A read of an undecoded offset returns 0, a write to one changes nothing, and `err` is high for the one cycle after either access.
- R11: `rd_data` shows the addressed register in the cycle after `rd_en`, zero-extended above bit 7. When a write to the same register happens in the same cycle, the read returns the value from before that write. In a cycle that follows no read, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address; bits 7:0 decoded |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data; bits 7:0 used |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data |
| err | output | 1 | One-cycle pulse after an access to an undecoded offset |
| ro_err | output | 1 | One-cycle pulse after a write to a constant location |

## Verification
The bench builds the block with ADDR_W = 16 and DATA_W = 32. The sixteen-bit address lets random upper bits sit above every decoded offset, which puts the 256-byte aliasing of R1 within reach on every access. The wide data bus exposes the zero extension of read data and carries random write bytes whose upper bits must be discarded. Directed cases cover the soft reset, reads that collide with writes to the same register, and a hardware reset in mid-run.

// File: rtl/uxb_pkg.sv
package uxb_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_MODEA,
        SEL_MODEB,
        SEL_SCTL,
        SEL_SSTAT,
        SEL_EBRK,
        SEL_CKSEL,
        SEL_VER,
        SEL_SCFG,
        SEL_SSTS,
        SEL_WAKE,
        SEL_PRESC
    } sel_e;

    typedef struct packed {
        logic [7:0] mode_a;
        logic [7:0] mode_b;
        logic [7:0] sctl;
        logic [7:0] ebrk;
        logic       cksel;
        logic [7:0] scfg;
        logic [7:0] wake;
        logic [7:0] presc;
    } regs_t;

    localparam logic [7:0] MASK_MODEA = 8'h7F;
    localparam logic [7:0] MASK_SCFG  = 8'h1D;
    localparam logic [7:0] MASK_WAKE  = 8'h7F;
    localparam int         SCFG_RST_BIT = 1;

    localparam logic [7:0] DEF_EBRK  = 8'h00;
    localparam logic [7:0] DEF_SCFG  = 8'h00;
    localparam logic [7:0] DEF_WAKE  = 8'h3F;
    localparam logic [7:0] DEF_PRESC = 8'h69;
    localparam logic       DEF_CKSEL = 1'b0;

    localparam logic [7:0] VAL_SSTAT = 8'h00;
    localparam logic [7:0] VAL_VER   = 8'h30;
    localparam logic [7:0] VAL_SSTS  = 8'h01;

    function automatic sel_e offset_to_sel(input logic [7:0] off);
        sel_e s;
        case (off)
            8'h20:   s = SEL_MODEA;
            8'h24:   s = SEL_MODEB;
            8'h40:   s = SEL_SCTL;
            8'h44:   s = SEL_SSTAT;
            8'h48:   s = SEL_EBRK;
            8'h4C:   s = SEL_CKSEL;
            8'h50:   s = SEL_VER;
            8'h54:   s = SEL_SCFG;
            8'h58:   s = SEL_SSTS;
            8'h5C:   s = SEL_WAKE;
            8'h60:   s = SEL_PRESC;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic is_const(input sel_e s);
        return (s == SEL_SSTAT) || (s == SEL_VER) || (s == SEL_SSTS);
    endfunction

    function automatic regs_t soft_defaults(input regs_t cur);
        regs_t r;
        r       = cur;
        r.ebrk  = DEF_EBRK;
        r.scfg  = DEF_SCFG;
        r.wake  = DEF_WAKE;
        r.presc = DEF_PRESC;
        r.cksel = DEF_CKSEL;
        return r;
    endfunction

    function automatic regs_t hard_defaults();
        regs_t r;
        r        = '0;
        r        = soft_defaults(r);
        r.mode_a = 8'h00;
        r.mode_b = 8'h00;
        r.sctl   = 8'h00;
        return r;
    endfunction

    function automatic logic [7:0] read_value(input sel_e s, input regs_t r);
        logic [7:0] v;
        case (s)
            SEL_MODEA: v = r.mode_a;
            SEL_MODEB: v = r.mode_b;
            SEL_SCTL:  v = r.sctl;
            SEL_SSTAT: v = VAL_SSTAT;
            SEL_EBRK:  v = r.ebrk;
            SEL_CKSEL: v = {7'b0, r.cksel};
            SEL_VER:   v = VAL_VER;
            SEL_SCFG:  v = r.scfg;
            SEL_SSTS:  v = VAL_SSTS;
            SEL_WAKE:  v = r.wake;
            SEL_PRESC: v = r.presc;
            default:   v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/uxb_decode.sv
module uxb_decode
    import uxb_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel
);
    logic unused_addr_hi;

    assign unused_addr_hi = ^addr[ADDR_W-1:8];
    assign sel = offset_to_sel(addr[7:0]);
endmodule

// File: rtl/uxb_regfile.sv
module uxb_regfile
    import uxb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  sel_e       sel,
    input  logic [7:0] wdata,
    output regs_t      regs
);
    regs_t nxt;

    always_comb begin
        nxt = regs;
        if (wr_en) begin
            case (sel)
                SEL_MODEA: nxt.mode_a = wdata & MASK_MODEA;
                SEL_MODEB: nxt.mode_b = wdata;
                SEL_SCTL:  nxt.sctl   = wdata;
                SEL_EBRK:  nxt.ebrk   = wdata;
                SEL_CKSEL: nxt.cksel  = wdata[0];
                SEL_SCFG: begin
                    if (wdata[SCFG_RST_BIT]) nxt = soft_defaults(regs);
                    else                     nxt.scfg = wdata & MASK_SCFG;
                end
                SEL_WAKE:  nxt.wake   = wdata & MASK_WAKE;
                SEL_PRESC: nxt.presc  = wdata;
                default:   nxt = regs;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs <= hard_defaults();
        else     regs <= nxt;
    end

    // R7
    soft_keep_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_SCFG && wdata[SCFG_RST_BIT]) |=>
            (regs.mode_a == $past(regs.mode_a) && regs.mode_b == $past(regs.mode_b)
             && regs.sctl == $past(regs.sctl)));

    // R7
    soft_defaults_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_SCFG && wdata[SCFG_RST_BIT]) |=>
            (regs.presc == DEF_PRESC && regs.wake == DEF_WAKE && regs.scfg == 8'h00));

    // R4
    const_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_const(sel)) |=> $stable(regs));

    // R10
    bad_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_NONE) |=> $stable(regs));
endmodule

// File: rtl/uxb_rdport.sv
module uxb_rdport
    import uxb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  sel_e              sel,
    input  regs_t             regs,
    output logic [DATA_W-1:0] rd_data,
    output logic              err,
    output logic              ro_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            err     <= 1'b0;
            ro_err  <= 1'b0;
        end else begin
            rd_data <= rd_en ? DATA_W'(read_value(sel, regs)) : '0;
            err     <= (rd_en || wr_en) && (sel == SEL_NONE);
            ro_err  <= wr_en && is_const(sel);
        end
    end

    // R11
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_data == '0));

    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(rd_en || wr_en));

    // R4
    err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(err && ro_err));

    // R11
    hi_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data >> 8) == '0);
endmodule

// File: rtl/uxb_ext_regs.sv
module uxb_ext_regs
    import uxb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              err,
    output logic              ro_err
);
    sel_e  sel;
    regs_t regs;
    logic  unused_wdata_hi;

    generate
        if (DATA_W > 8) begin : g_wide
            assign unused_wdata_hi = ^wr_data[DATA_W-1:8];
        end else begin : g_narrow
            assign unused_wdata_hi = 1'b0;
        end
    endgenerate

    uxb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    uxb_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .sel   (sel),
        .wdata (wr_data[7:0]),
        .regs  (regs)
    );

    uxb_rdport #(.DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .sel     (sel),
        .regs    (regs),
        .rd_data (rd_data),
        .err     (err),
        .ro_err  (ro_err)
    );
endmodule

// File: tb/sim_uxb_ext_regs.sv
module sim_uxb_ext_regs;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              err;
    logic              ro_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uxb_ext_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .err(err), .ro_err(ro_err)
    );

    logic [7:0] m_ma, m_mb, m_sc, m_eb, m_cf, m_wk, m_ps;
    logic       m_cs;

    task automatic model_hw_reset();
        m_ma = 8'h00; m_mb = 8'h00; m_sc = 8'h00; m_eb = 8'h00;
        m_cf = 8'h00; m_wk = 8'h3F; m_ps = 8'h69; m_cs = 1'b0;
    endtask

    function automatic bit m_valid(input logic [7:0] o);
        return o inside {8'h20, 8'h24, 8'h40, 8'h44, 8'h48, 8'h4C,
                         8'h50, 8'h54, 8'h58, 8'h5C, 8'h60};
    endfunction

    function automatic bit m_const(input logic [7:0] o);
        return o inside {8'h44, 8'h50, 8'h58};
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] o);
        case (o)
            8'h20: return m_ma;
            8'h24: return m_mb;
            8'h40: return m_sc;
            8'h44: return 8'h00;
            8'h48: return m_eb;
            8'h4C: return {7'b0, m_cs};
            8'h50: return 8'h30;
            8'h54: return m_cf;
            8'h58: return 8'h01;
            8'h5C: return m_wk;
            8'h60: return m_ps;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] o, input logic [7:0] d);
        case (o)
            8'h20: m_ma = {1'b0, d[6:0]};
            8'h24: m_mb = d;
            8'h40: m_sc = d;
            8'h48: m_eb = d;
            8'h4C: m_cs = d[0];
            8'h54: begin
                if (d[1]) begin
                    m_eb = 8'h00; m_cf = 8'h00; m_wk = 8'h3F;
                    m_ps = 8'h69; m_cs = 1'b0;
                end else begin
                    m_cf = {3'b0, d[4], d[3], d[2], 1'b0, d[0]};
                end
            end
            8'h5C: m_wk = {1'b0, d[6:0]};
            8'h60: m_ps = d;
            default: ;
        endcase
    endtask

    task automatic chk(input string tag, input logic [DATA_W-1:0] got,
                       input logic [DATA_W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one bus cycle: inputs set at a falling edge, results sampled one edge later
    task automatic op(input bit r, input bit w, input logic [7:0] off,
                      input logic [7:0] hi, input logic [DATA_W-1:0] d, input string tag);
        logic [7:0] exp_rd;
        bit exp_err, exp_ro;
        exp_rd  = r ? m_read(off) : 8'h00;
        exp_err = (r || w) && !m_valid(off);
        exp_ro  = w && m_const(off);
        addr    = {hi, off};
        rd_en   = r;
        wr_en   = w;
        wr_data = d;
        @(posedge clk);
        if (w) model_write(off, d[7:0]);
        @(negedge clk);
        rd_en = 1'b0;
        wr_en = 1'b0;
        chk({tag, " rd_data"}, rd_data, DATA_W'(exp_rd));
        chk({tag, " err"}, DATA_W'(err), DATA_W'(exp_err));
        chk({tag, " ro_err"}, DATA_W'(ro_err), DATA_W'(exp_ro));
    endtask

    task automatic rd(input logic [7:0] off, input string tag);
        op(1'b1, 1'b0, off, 8'h00, '0, tag);
    endtask

    task automatic wr(input logic [7:0] off, input logic [DATA_W-1:0] d, input string tag);
        op(1'b0, 1'b1, off, 8'h00, d, tag);
    endtask

    task automatic read_all(input string tag);
        logic [7:0] offs [11] = '{8'h20, 8'h24, 8'h40, 8'h44, 8'h48, 8'h4C,
                                  8'h50, 8'h54, 8'h58, 8'h5C, 8'h60};
        foreach (offs[i]) rd(offs[i], tag);
    endtask

    task automatic hw_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        model_hw_reset();
        chk("R9 rd_data in reset", rd_data, '0);
        chk("R9 err in reset", DATA_W'(err), '0);
        chk("R9 ro_err in reset", DATA_W'(ro_err), '0);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] offs [11] = '{8'h20, 8'h24, 8'h40, 8'h44, 8'h48, 8'h4C,
                                  8'h50, 8'h54, 8'h58, 8'h5C, 8'h60};
        void'($urandom(32'h5EED_0A11));
        @(negedge clk);
        hw_reset();
        read_all("R9 reset values");

        // R2 R3 R5 R8 masks
        wr(8'h20, 32'hFFFF_FFFF, "R2 mode A write"); rd(8'h20, "R2 mode A mask");
        wr(8'h24, 32'h0000_00A5, "R2 mode B write"); rd(8'h24, "R2 mode B");
        wr(8'h40, 32'h0000_00C3, "R3 sctl write");   rd(8'h40, "R3 sctl");
        wr(8'h48, 32'h0000_00FE, "R3 ebrk write");   rd(8'h48, "R3 ebrk");
        wr(8'h4C, 32'h0000_00FF, "R5 cksel write");  rd(8'h4C, "R5 cksel mask");
        wr(8'h5C, 32'h0000_00FF, "R8 wake write");   rd(8'h5C, "R8 wake mask");
        wr(8'h60, 32'h0000_0012, "R8 presc write");  rd(8'h60, "R8 presc");
        wr(8'h54, 32'h0000_00FD, "R6 scfg write");   rd(8'h54, "R6 scfg mask");

        // R4 constant locations ignore writes
        wr(8'h44, 32'h0000_00FF, "R4 sstat write"); rd(8'h44, "R4 sstat");
        wr(8'h50, 32'h0000_0000, "R4 ver write");   rd(8'h50, "R4 ver");
        wr(8'h58, 32'h0000_0000, "R4 ssts write");  rd(8'h58, "R4 ssts");

        // R6 R7 soft reset
        wr(8'h54, 32'h0000_0002, "R6 soft reset");
        read_all("R7 after soft reset");

        // R1 aliasing through upper address bits
        op(1'b0, 1'b1, 8'h24, 8'hC7, 32'h0000_005A, "R1 alias write");
        rd(8'h24, "R1 alias read");
        op(1'b1, 1'b0, 8'h24, 8'h3B, '0, "R1 alias read high");

        // R10 undecoded offsets
        wr(8'h22, 32'h0000_00FF, "R10 unaligned write");
        wr(8'h2C, 32'h0000_00FF, "R10 gap write");
        rd(8'h1C, "R10 below read");
        rd(8'h64, "R10 above read");
        rd(8'h23, "R10 unaligned read");
        read_all("R10 state unchanged");

        // R11 same-cycle read and write returns old value; idle gives zero
        op(1'b1, 1'b1, 8'h60, 8'h00, 32'h0000_00E1, "R11 read during write");
        rd(8'h60, "R11 value after write");
        op(1'b0, 1'b0, 8'h60, 8'h00, '0, "R11 idle cycle");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] o;
            bit r, w;
            o = ($urandom_range(0, 3) == 0) ? 8'($urandom) : offs[$urandom_range(0, 10)];
            r = $urandom_range(0, 1);
            w = $urandom_range(0, 1);
            op(r, w, o, 8'($urandom), $urandom, "R10 R11 random");
        end

        // R9 reset in mid-run
        hw_reset();
        read_all("R9 reset after traffic");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule